// File: doc/BRIEF.md
# Four-Channel Trigger Delay and Pulse Generator

This block takes one trigger line, already synchronized to the system clock, and drives four output channels from it. A channel that is enabled waits for a rising edge on the trigger. It then counts a programmed number of whole clock periods and produces an output pulse. The pulse lasts a programmed number of clock ticks. The delay is held in 1 ns units. The upper bits of the delay choose the coarse tick count handled in logic. The three lowest bits are a sub-cycle residue, and the block presents it on a per-channel fine code bus for an external fine-delay element to apply. With a clock of about 125 MHz, one tick is 8 ns.

Software programs each channel through a small write port that has a channel select, a field select and a data word. The delay word is 38 bits wide, which covers more than 120 s at 1 ns steps. The width field is 16 bits. A channel copies its delay and width when a trigger is accepted. Writes made while a delay or pulse is running therefore do not change that delay or pulse.

Top module: `pdg_top`

## Requirements
- R1: During reset and right after it, every output pulse is low, every fine code is 0 and every channel is disabled with delay and width 0.
- R2: For a delay D, the output rises exactly floor(D/8)+1 clock edges after the edge that first samples the trigger high. From that edge until the pulse ends, the channel's fine code equals D mod 8, taken from bits [2:0] of the delay.
- R3: The output stays high for exactly W clock cycles, where W is the programmed width.
- R4: Only a low-to-high transition of the trigger starts a channel. A trigger held high produces a single pulse.
- R5: A trigger edge that arrives while a channel is counting its delay or emitting its pulse is ignored. Once the pulse ends, the channel is armed again.
- R6: A channel whose enable bit (field 2, bit 0) is 0 keeps its output low. Clearing the enable aborts a delay in progress, and the output is low by the second edge after the write.
- R7: A width of 0 produces no pulse.
- R8: Writes to delay (field 0) or width (field 1) made during a delay or pulse do not change that delay or pulse. They apply from the next accepted trigger.
- R9: All four channels share the trigger and time independently, each with its own delay, width and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Synchronized trigger shared by all channels |
| wr_en_i | input | 1 | Register write strobe |
| wr_chan_i | input | 2 | Channel addressed by the write |
| wr_field_i | input | 2 | 0 delay, 1 width, 2 enable, 3 unused |
| wr_data_i | input | 38 | Write data; width uses [15:0], enable uses [0] |
| pulse_o | output | 4 | Per-channel output pulse |
| fine_o | output | 12 | Per-channel 3-bit fine code, channel c at [3c+2:3c] |

## Verification
If a channel's coarse counter is wrong, the output edge moves by whole clock cycles, or the pulse comes out too long or too short. The bench sees this on the first triggered pulse, because it measures the rise cycle and the high count against the delay and width it wrote. If the channel's state is wrong, the symptoms are different. A retrigger may slip through while the channel is busy. A trigger held high may give a second pulse. A disabled channel may keep running. In each case the pulse count or pulse position on pulse_o is off within a single delay window. A lost residue shows up as a wrong fine code at the edge where the pulse rises.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_DELAY = 2'd1,
        CH_PULSE = 2'd2
    } ch_state_e;

    localparam int FIELD_DELAY  = 0;
    localparam int FIELD_WIDTH  = 1;
    localparam int FIELD_ENABLE = 2;
endpackage

// File: rtl/pdg_edge.sv
module pdg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);
    logic trig_d, trig_q;

    always_comb begin
        trig_d = trig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end

    assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/pdg_regs.sv
module pdg_regs #(
    parameter int NCH     = 4,
    parameter int DELAY_W = 38,
    parameter int WIDTH_W = 16,
    parameter int CH_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [CH_W-1:0]          wr_chan_i,
    input  logic [1:0]               wr_field_i,
    input  logic [DELAY_W-1:0]       wr_data_i,
    output logic [NCH*DELAY_W-1:0]   dly_o,
    output logic [NCH*WIDTH_W-1:0]   wid_o,
    output logic [NCH-1:0]           en_o
);
    import pdg_pkg::*;

    typedef struct packed {
        logic [NCH-1:0][DELAY_W-1:0] dly;
        logic [NCH-1:0][WIDTH_W-1:0] wid;
        logic [NCH-1:0]              en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i && (int'(wr_chan_i) < NCH)) begin
            case (int'(wr_field_i))
                FIELD_DELAY:  r_d.dly[wr_chan_i] = wr_data_i;
                FIELD_WIDTH:  r_d.wid[wr_chan_i] = wr_data_i[WIDTH_W-1:0];
                FIELD_ENABLE: r_d.en[wr_chan_i]  = wr_data_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dly_o = r_q.dly;
    assign wid_o = r_q.wid;
    assign en_o  = r_q.en;
endmodule

// File: rtl/pdg_channel.sv
module pdg_channel #(
    parameter int DELAY_W = 38,
    parameter int WIDTH_W = 16,
    parameter int FINE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_i,
    input  logic               en_i,
    input  logic [DELAY_W-1:0] dly_i,
    input  logic [WIDTH_W-1:0] wid_i,
    output logic               pulse_o,
    output logic [FINE_W-1:0]  fine_o
);
    import pdg_pkg::*;

    localparam int CNT_W = DELAY_W - FINE_W;

    typedef struct packed {
        ch_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [WIDTH_W-1:0] wcnt;
        logic [FINE_W-1:0]  fine_hold;
        logic [FINE_W-1:0]  fine;
        logic               out;
    } ch_t;

    ch_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            CH_IDLE: begin
                if (rise_i && (wid_i != '0)) begin
                    s_d.st        = CH_DELAY;
                    s_d.cnt       = dly_i[DELAY_W-1:FINE_W];
                    s_d.wcnt      = wid_i;
                    s_d.fine_hold = dly_i[FINE_W-1:0];
                end
            end
            CH_DELAY: begin
                if (s_q.cnt == '0) begin
                    s_d.st   = CH_PULSE;
                    s_d.out  = 1'b1;
                    s_d.fine = s_q.fine_hold;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            CH_PULSE: begin
                if (s_q.wcnt == WIDTH_W'(1)) begin
                    s_d.st  = CH_IDLE;
                    s_d.out = 1'b0;
                end else begin
                    s_d.wcnt = s_q.wcnt - 1'b1;
                end
            end
            default: begin
                s_d.st  = CH_IDLE;
                s_d.out = 1'b0;
            end
        endcase
        if (!en_i) begin
            s_d.st  = CH_IDLE;
            s_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: CH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign pulse_o = s_q.out;
    assign fine_o  = s_q.fine;
endmodule

// File: rtl/pdg_top.sv
module pdg_top #(
    parameter int NCH     = 4,
    parameter int DELAY_W = 38,
    parameter int WIDTH_W = 16,
    parameter int FINE_W  = 3,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig_i,
    input  logic                    wr_en_i,
    input  logic [CH_W-1:0]         wr_chan_i,
    input  logic [1:0]              wr_field_i,
    input  logic [DELAY_W-1:0]      wr_data_i,
    output logic [NCH-1:0]          pulse_o,
    output logic [NCH*FINE_W-1:0]   fine_o
);
    logic                   rise;
    logic [NCH*DELAY_W-1:0] dly_all;
    logic [NCH*WIDTH_W-1:0] wid_all;
    logic [NCH-1:0]         en_all;

    pdg_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .rise_o (rise)
    );

    pdg_regs #(
        .NCH(NCH), .DELAY_W(DELAY_W), .WIDTH_W(WIDTH_W), .CH_W(CH_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_chan_i  (wr_chan_i),
        .wr_field_i (wr_field_i),
        .wr_data_i  (wr_data_i),
        .dly_o      (dly_all),
        .wid_o      (wid_all),
        .en_o       (en_all)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pdg_channel #(
            .DELAY_W(DELAY_W), .WIDTH_W(WIDTH_W), .FINE_W(FINE_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_i  (rise),
            .en_i    (en_all[c]),
            .dly_i   (dly_all[c*DELAY_W +: DELAY_W]),
            .wid_i   (wid_all[c*WIDTH_W +: WIDTH_W]),
            .pulse_o (pulse_o[c]),
            .fine_o  (fine_o[c*FINE_W +: FINE_W])
        );
    end
endmodule

// File: rtl/pdg_top_chk.sv
module pdg_top_chk #(
    parameter int NCH     = 4,
    parameter int DELAY_W = 38,
    parameter int FINE_W  = 3,
    parameter int CH_W    = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  trig_i,
    input logic                  wr_en_i,
    input logic [CH_W-1:0]       wr_chan_i,
    input logic [1:0]            wr_field_i,
    input logic [DELAY_W-1:0]    wr_data_i,
    input logic [NCH-1:0]        pulse_o,
    input logic [NCH*FINE_W-1:0] fine_o
);
    logic trig_prev, seen_trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_prev <= 1'b0;
            seen_trig <= 1'b0;
        end else begin
            trig_prev <= trig_i;
            if (trig_i && !trig_prev) seen_trig <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (pulse_o == '0) && (fine_o == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_fine_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[c] && $past(pulse_o[c]) |-> $stable(fine_o[c*FINE_W +: FINE_W]));

        assert_pulse_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pulse_o[c]) |-> seen_trig);

        assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i && (int'(wr_chan_i) == c) && (wr_field_i == 2'd2) && !wr_data_i[0]
            |=> ##1 !pulse_o[c]);
    end
endmodule

bind pdg_top pdg_top_chk #(
    .NCH(NCH), .DELAY_W(DELAY_W), .FINE_W(FINE_W), .CH_W(CH_W)
) u_pdg_top_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .wr_en_i    (wr_en_i),
    .wr_chan_i  (wr_chan_i),
    .wr_field_i (wr_field_i),
    .wr_data_i  (wr_data_i),
    .pulse_o    (pulse_o),
    .fine_o     (fine_o)
);

// File: tb/test_pdg_top.sv
module test_pdg_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NVEC = 8;
    // delay (ns), width (ticks), expected rise edge = delay/8+1, expected fine = delay%8
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{0,    1,   1,   0},
        '{7,    3,   1,   7},
        '{8,    2,   2,   0},
        '{25,   5,   4,   1},
        '{100,  1,   13,  4},
        '{203,  10,  26,  3},
        '{1000, 4,   126, 0},
        '{17,   300, 3,   1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [1:0]  wr_field = '0;
    logic [37:0] wr_data = '0;
    logic [3:0]  pulse;
    logic [11:0] fine;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int first_k [NCH];
    int hi_cnt  [NCH];
    int rises   [NCH];
    int fine_at [NCH];

    pdg_top i_pdg_top (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .wr_en_i(wr_en), .wr_chan_i(wr_chan), .wr_field_i(wr_field),
        .wr_data_i(wr_data), .pulse_o(pulse), .fine_o(fine)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write(input int ch, input int field, input longint data);
        wr_en = 1'b1; wr_chan = 2'(ch); wr_field = 2'(field); wr_data = 38'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int ch, input longint dly, input int wid, input int en);
        write(ch, 0, dly);
        write(ch, 1, wid);
        write(ch, 2, en);
    endtask

    // Called at a negedge; trigger goes high here, k counts edges after the one that samples it.
    task automatic observe(input int ncyc, input int hi_len, input int edge2,
                           input int w_at, input int w_ch, input int w_field, input longint w_data);
        logic [3:0] prev = '0;
        for (int c = 0; c < NCH; c++) begin
            first_k[c] = -1; hi_cnt[c] = 0; rises[c] = 0; fine_at[c] = -1;
        end
        trig = 1'b1;
        for (int n = 1; n <= ncyc; n++) begin
            @(posedge clk);
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                if (pulse[c]) begin
                    hi_cnt[c]++;
                    if (!prev[c]) begin
                        rises[c]++;
                        if (first_k[c] < 0) begin
                            first_k[c] = n - 1;
                            fine_at[c] = int'(fine[c*3 +: 3]);
                        end
                    end
                end
            end
            prev = pulse;
            if (n == hi_len) trig = 1'b0;
            if (edge2 > 0 && n == edge2) trig = 1'b1;
            if (edge2 > 0 && n == edge2 + 2) trig = 1'b0;
            if (n == w_at) begin
                wr_en = 1'b1; wr_chan = 2'(w_ch); wr_field = 2'(w_field); wr_data = 38'(w_data);
            end
            if (n == w_at + 1) wr_en = 1'b0;
        end
        trig = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pulse == '0, "R1", pulse, 0);
        check(fine == '0, "R1", fine, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all channels disabled after reset, trigger gives nothing
        observe(20, 5, 0, 0, 0, 0, 0);
        check(rises[0] + rises[1] + rises[2] + rises[3] == 0, "R1", rises[0], 0);

        // Vector table on channel 0: R2 rise edge and fine code, R3 width
        for (int v = 0; v < NVEC; v++) begin
            setup(0, VEC[v][0], VEC[v][1], 1);
            observe(VEC[v][2] + VEC[v][1] + 5, 13, 0, 0, 0, 0, 0);
            check(first_k[0] == VEC[v][2], "R2", first_k[0], VEC[v][2]);
            check(fine_at[0] == VEC[v][3], "R2", fine_at[0], VEC[v][3]);
            check(hi_cnt[0] == VEC[v][1], "R3", hi_cnt[0], VEC[v][1]);
        end

        // R7: width zero gives no pulse
        setup(0, 16, 0, 1);
        observe(30, 5, 0, 0, 0, 0, 0);
        check(hi_cnt[0] == 0, "R7", hi_cnt[0], 0);

        // R4: trigger held high for 40 cycles produces one pulse only
        setup(0, 0, 2, 1);
        observe(50, 40, 0, 0, 0, 0, 0);
        check(rises[0] == 1, "R4", rises[0], 1);

        // R5: second edge during the delay is ignored
        setup(0, 80, 3, 1);
        observe(30, 2, 5, 0, 0, 0, 0);
        check(rises[0] == 1, "R5", rises[0], 1);
        check(first_k[0] == 11, "R5", first_k[0], 11);
        // R5: re-armed after the pulse
        observe(20, 2, 0, 0, 0, 0, 0);
        check(first_k[0] == 11, "R5", first_k[0], 11);

        // R8: width write during delay does not change the running pulse
        setup(0, 80, 4, 1);
        observe(25, 2, 0, 3, 0, 1, 1);
        check(hi_cnt[0] == 4, "R8", hi_cnt[0], 4);
        observe(25, 2, 0, 0, 0, 0, 0);
        check(hi_cnt[0] == 1, "R8", hi_cnt[0], 1);

        // R6: disabling during the delay aborts it
        setup(0, 400, 5, 1);
        observe(80, 3, 0, 10, 0, 2, 0);
        check(hi_cnt[0] == 0, "R6", hi_cnt[0], 0);
        observe(80, 3, 0, 0, 0, 0, 0);
        check(hi_cnt[0] == 0, "R6", hi_cnt[0], 0);

        // R9: independent channels on one trigger
        setup(1, 16, 2, 1);
        setup(2, 43, 1, 1);
        setup(3, 8, 3, 0);
        observe(20, 3, 0, 0, 0, 0, 0);
        check(first_k[1] == 3, "R9", first_k[1], 3);
        check(hi_cnt[1] == 2, "R9", hi_cnt[1], 2);
        check(first_k[2] == 6, "R9", first_k[2], 6);
        check(fine_at[2] == 3, "R9", fine_at[2], 3);
        check(hi_cnt[2] == 1, "R9", hi_cnt[2], 1);
        check(hi_cnt[3] == 0, "R9", hi_cnt[3], 0);
        check(hi_cnt[0] == 0, "R9", hi_cnt[0], 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule